// File: doc/BRIEF.md
# Hysteresis Lock Detector for a Phase-Frequency Detector

This block judges whether a phase-locked loop has settled by watching the UP and DOWN pulses of its phase-frequency detector. Both pulses are sampled by a fast clock. Over each phase-detector period, the block counts how many sampling cycles had either pulse active, and that count is the period's phase error. A single-cycle tick marks the end of each period. On the tick the error is compared against a fixed window of `WINDOW` sampling cycles.

A two-state machine (searching, locked) with one shared run counter supplies the hysteresis. Leaving the searching state takes a long run of in-window periods. Leaving the locked state takes only a short run of out-of-window periods. One precision input picks between two pairs of run lengths. A restart strobe sends the machine back to searching, for example after the loop has been given a new divide setting.

The single output pin carries one of three things, chosen by a 3-bit mode field: the filtered lock decision, the raw OR of UP and DOWN, or a constant low.

Top module: `lockdet_top`

## Requirements
- R1: The phase error of a period is the number of rising clock edges on which UP or DOWN was high, counted from the edge after the previous tick up to and including the tick edge. A period is in-window when its error is at most `WINDOW` (default 4) and out-of-window when its error exceeds it.
- R2: While searching, with `precSel`=0, each in-window period adds one to the run count. On the 15th consecutive in-window period the state becomes locked.
- R3: With `precSel`=1, locking takes 31 consecutive in-window periods and unlocking takes 7 consecutive out-of-window periods.
- R4: While locked, each out-of-window period adds one to the run count. With `precSel`=0, the 3rd consecutive out-of-window period returns the state to searching.
- R5: A period that breaks the run clears the run count to zero. While searching this is an out-of-window period; while locked it is an in-window period.
- R6: With `outMode`=3'b001, `lockOut` is high exactly while the state is locked. It changes in the cycle after the deciding tick edge.
- R7: With `outMode`=3'b101, `lockOut` equals UP OR DOWN in the same cycle, with no register on the way.
- R8: Every `outMode` value other than 3'b001 and 3'b101 drives `lockOut` low.
- R9: On the edge where `restart` is high, the block enters the searching state and clears both the run count and the error accumulation. If a tick arrives on the same edge, `restart` takes priority over it.
- R10: After reset the state is searching, the counts are zero, and `lockOut` is low in mode 3'b001.
- R11: The run count is zero after every change of state, so every run is counted afresh from its first period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pfdUp | input | 1 | UP pulse from the phase-frequency detector |
| pfdDn | input | 1 | DOWN pulse from the phase-frequency detector |
| pfdTick | input | 1 | One-cycle marker at the end of each phase-detector period |
| precSel | input | 1 | Run-length select: 0 gives 15/3, 1 gives 31/7 |
| outMode | input | 3 | Output select: 001 filtered lock, 101 raw UP OR DOWN, others low |
| restart | input | 1 | Returns the detector to the searching state |
| lockOut | output | 1 | Lock-detect output |

## Verification
The two functions that can fall in the same cycle are the restart strobe and the tick that evaluates a period. The bench builds a searching run of 14 in-window periods and then raises `restart` on the very edge of the 15th tick. The output must stay low, and 15 further in-window periods must be needed to lock. A second case raises `restart` in the middle of a pulse that would otherwise be out-of-window. That period must then count as in-window, which shows the error accumulation was cleared as well.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic inLock;   // selects unlock run length
    logic cntInc;
    logic cntClr;
  } hystCtl_t;
endpackage

// File: rtl/lockdet_dp.sv
module lockdet_dp
  import lockdet_pkg::*;
#(
  parameter int ACC_W     = 6,
  parameter int WINDOW    = 4,
  parameter int LOCK_LO   = 15,
  parameter int LOCK_HI   = 31,
  parameter int UNLOCK_LO = 3,
  parameter int UNLOCK_HI = 7,
  parameter int CNT_W     = $clog2(LOCK_HI + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             phaseAct,
  input  logic             pfdTick,
  input  logic             restart,
  input  logic             precSel,
  input  hystCtl_t         ctl,
  output logic             inWin,
  output logic             thrReach,
  output logic [CNT_W-1:0] hystCnt
);
  localparam logic [ACC_W-1:0] ACC_MAX = {ACC_W{1'b1}};

  logic [ACC_W-1:0] accQ;
  logic [ACC_W-1:0] errNow;
  logic [CNT_W:0]   thr;
  logic [CNT_W:0]   cntPlus;

  // error including the current (tick) cycle, saturating
  always_comb begin
    errNow = accQ;
    if (phaseAct && accQ != ACC_MAX) errNow = accQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     accQ <= '0;
    else if (restart || pfdTick)   accQ <= '0;
    else                           accQ <= errNow;
  end

  assign inWin = (int'(errNow) <= WINDOW);

  always_comb begin
    if (ctl.inLock) thr = precSel ? (CNT_W+1)'(UNLOCK_HI) : (CNT_W+1)'(UNLOCK_LO);
    else            thr = precSel ? (CNT_W+1)'(LOCK_HI)   : (CNT_W+1)'(LOCK_LO);
    cntPlus  = {1'b0, hystCnt} + 1'b1;
    thrReach = (cntPlus >= thr);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           hystCnt <= '0;
    else if (ctl.cntClr) hystCnt <= '0;
    else if (ctl.cntInc) hystCnt <= cntPlus[CNT_W-1:0];
  end
endmodule

// File: rtl/lockdet_ctl.sv
module lockdet_ctl
  import lockdet_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     pfdTick,
  input  logic     restart,
  input  logic     inWin,
  input  logic     thrReach,
  output hystCtl_t ctl,
  output logic     lockedQ
);
  logic lockNext;
  logic runOk;

  always_comb begin
    lockNext   = lockedQ;
    ctl.inLock = lockedQ;
    ctl.cntInc = 1'b0;
    ctl.cntClr = 1'b0;
    runOk      = lockedQ ? !inWin : inWin;
    if (restart) begin
      lockNext   = 1'b0;
      ctl.cntClr = 1'b1;
    end else if (pfdTick) begin
      if (!runOk) begin
        ctl.cntClr = 1'b1;
      end else if (thrReach) begin
        lockNext   = !lockedQ;
        ctl.cntClr = 1'b1;
      end else begin
        ctl.cntInc = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lockedQ <= 1'b0;
    else       lockedQ <= lockNext;
  end
endmodule

// File: rtl/lockdet_top.sv
module lockdet_top
  import lockdet_pkg::*;
#(
  parameter int ACC_W     = 6,
  parameter int WINDOW    = 4,
  parameter int LOCK_LO   = 15,
  parameter int LOCK_HI   = 31,
  parameter int UNLOCK_LO = 3,
  parameter int UNLOCK_HI = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pfdUp,
  input  logic       pfdDn,
  input  logic       pfdTick,
  input  logic       precSel,
  input  logic [2:0] outMode,
  input  logic       restart,
  output logic       lockOut
);
  localparam int CNT_W = $clog2(LOCK_HI + 1);

  hystCtl_t         ctl;
  logic             inWin;
  logic             thrReach;
  logic [CNT_W-1:0] hystCnt;
  logic             lockedQ;
  logic             phaseAct;

  assign phaseAct = pfdUp | pfdDn;

  lockdet_dp #(
    .ACC_W(ACC_W), .WINDOW(WINDOW), .LOCK_LO(LOCK_LO), .LOCK_HI(LOCK_HI),
    .UNLOCK_LO(UNLOCK_LO), .UNLOCK_HI(UNLOCK_HI), .CNT_W(CNT_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .phaseAct(phaseAct), .pfdTick(pfdTick),
    .restart(restart), .precSel(precSel), .ctl(ctl),
    .inWin(inWin), .thrReach(thrReach), .hystCnt(hystCnt)
  );

  lockdet_ctl uCtl (
    .clk(clk), .rstN(rstN), .pfdTick(pfdTick), .restart(restart),
    .inWin(inWin), .thrReach(thrReach), .ctl(ctl), .lockedQ(lockedQ)
  );

  always_comb begin
    case (outMode)
      3'b001:  lockOut = lockedQ;
      3'b101:  lockOut = phaseAct;
      default: lockOut = 1'b0;
    endcase
  end
endmodule

// File: rtl/lockdet_chk.sv
module lockdet_chk #(
  parameter int CNT_W   = 5,
  parameter int LOCK_HI = 31
) (
  input logic             clk,
  input logic             rstN,
  input logic             pfdUp,
  input logic             pfdDn,
  input logic             pfdTick,
  input logic             restart,
  input logic [2:0]       outMode,
  input logic             lockOut,
  input logic             lockedQ,
  input logic [CNT_W-1:0] hystCnt
);
  p_lock_needs_tick_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockedQ) |-> $past(pfdTick && !restart));

  p_unlock_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lockedQ) |-> $past(pfdTick || restart));

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    int'(hystCnt) < LOCK_HI);

  p_digital_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outMode == 3'b001) |-> (lockOut == lockedQ));

  p_analog_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outMode == 3'b101) |-> (lockOut == (pfdUp | pfdDn)));

  p_other_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(outMode == 3'b001 || outMode == 3'b101) |-> !lockOut);

  p_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> (!lockedQ && hystCnt == '0));

  p_trans_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(lockedQ) || $fell(lockedQ)) |-> (hystCnt == '0));
endmodule

bind lockdet_top lockdet_chk #(.CNT_W(CNT_W), .LOCK_HI(LOCK_HI)) uChk (
  .clk(clk), .rstN(rstN), .pfdUp(pfdUp), .pfdDn(pfdDn), .pfdTick(pfdTick),
  .restart(restart), .outMode(outMode), .lockOut(lockOut),
  .lockedQ(lockedQ), .hystCnt(hystCnt)
);

// File: tb/tb_lockdet_top.sv
module tb_lockdet_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pfdUp = 1'b0, pfdDn = 1'b0, pfdTick = 1'b0;
  logic       precSel = 1'b0, restart = 1'b0;
  logic [2:0] outMode = 3'b001;
  logic       lockOut;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  lockdet_top dut (
    .clk(clk), .rstN(rstN), .pfdUp(pfdUp), .pfdDn(pfdDn), .pfdTick(pfdTick),
    .precSel(precSel), .outMode(outMode), .restart(restart), .lockOut(lockOut)
  );

  // {restart first, precSel, pulse width, repeats, expected mid, expected final}
  typedef struct packed {
    logic       rst;
    logic       prec;
    logic [3:0] width;
    logic [5:0] reps;
    logic       mid;
    logic       fin;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 4'd2,  6'd14, 1'b0, 1'b0},  // R2 building run
    '{1'b0, 1'b0, 4'd2,  6'd1,  1'b0, 1'b1},  // R2 15th locks
    '{1'b0, 1'b0, 4'd9,  6'd2,  1'b1, 1'b1},  // R4 R11 two outs, still locked
    '{1'b0, 1'b0, 4'd1,  6'd1,  1'b1, 1'b1},  // R5 in-window clears
    '{1'b0, 1'b0, 4'd9,  6'd2,  1'b1, 1'b1},  // R5 counting from zero again
    '{1'b0, 1'b0, 4'd9,  6'd1,  1'b1, 1'b0},  // R4 third out unlocks
    '{1'b0, 1'b0, 4'd4,  6'd10, 1'b0, 1'b0},  // R1 width 4 is in-window
    '{1'b0, 1'b0, 4'd5,  6'd1,  1'b0, 1'b0},  // R1 R5 width 5 out, clears
    '{1'b0, 1'b0, 4'd4,  6'd14, 1'b0, 1'b0},  // R5 fresh run
    '{1'b0, 1'b0, 4'd4,  6'd1,  1'b0, 1'b1},  // R2 locks
    '{1'b1, 1'b1, 4'd0,  6'd30, 1'b0, 1'b0},  // R3 R9 restart, long run
    '{1'b0, 1'b1, 4'd0,  6'd1,  1'b0, 1'b1},  // R3 31st locks
    '{1'b0, 1'b1, 4'd10, 6'd6,  1'b1, 1'b1},  // R3 six outs hold lock
    '{1'b0, 1'b1, 4'd10, 6'd1,  1'b1, 1'b0}   // R3 seventh unlocks
  };

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s lockOut=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // one phase-detector period of 16 sampling cycles; tick in the last one
  task automatic pfdCycle(input int w, input int rstAt);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      pfdUp   = (w < 9) && (i < w);
      pfdDn   = (w >= 9) && (i < w);
      restart = (i == rstAt);
      pfdTick = (i == 15);
    end
    @(negedge clk);
    pfdUp = 1'b0; pfdDn = 1'b0; pfdTick = 1'b0; restart = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check(lockOut, 1'b0, "R10 in reset");
    rstN = 1'b1;
    @(negedge clk);
    check(lockOut, 1'b0, "R10 after reset");

    // vector table walk
    for (int v = 0; v < NV; v++) begin
      precSel = VEC[v].prec;
      if (VEC[v].rst) begin
        @(negedge clk); restart = 1'b1;
        @(negedge clk); restart = 1'b0;
      end
      for (int r = 0; r < int'(VEC[v].reps); r++) begin
        pfdCycle(int'(VEC[v].width), -1);
        check(lockOut, (r == int'(VEC[v].reps) - 1) ? VEC[v].fin : VEC[v].mid,
              $sformatf("table R2 R3 R4 R5 entry %0d rep %0d", v, r));
      end
    end

    // R9: restart on the same edge as the 15th tick
    precSel = 1'b0;
    for (int k = 0; k < 14; k++) pfdCycle(2, -1);
    pfdCycle(2, 15);
    check(lockOut, 1'b0, "R9 restart beats tick");
    for (int k = 0; k < 14; k++) pfdCycle(2, -1);
    check(lockOut, 1'b0, "R9 R11 run restarted from zero");
    pfdCycle(2, -1);
    check(lockOut, 1'b1, "R9 lock after fresh 15");

    // R8 / R6 output modes while locked
    for (int m = 0; m < 8; m++) begin
      @(negedge clk); outMode = 3'(m);
      @(negedge clk);
      if (m == 1)      check(lockOut, 1'b1, "R6 mode 001 shows lock");
      else if (m != 5) check(lockOut, 1'b0, $sformatf("R8 mode %0d low", m));
    end
    // R7 raw indication
    outMode = 3'b101;
    @(negedge clk); pfdUp = 1'b1; #1 check(lockOut, 1'b1, "R7 up high");
    @(negedge clk); pfdUp = 1'b0; pfdDn = 1'b1; #1 check(lockOut, 1'b1, "R7 dn high");
    @(negedge clk); pfdDn = 1'b0; #1 check(lockOut, 1'b0, "R7 both low");
    outMode = 3'b001;

    // R9: lone restart unlocks, and clears error accumulation
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;
    check(lockOut, 1'b0, "R9 restart unlocks");
    pfdCycle(9, 5);   // only 3 active cycles after restart -> in-window
    for (int k = 0; k < 13; k++) pfdCycle(2, -1);
    check(lockOut, 1'b0, "R9 14 in-window so far");
    pfdCycle(2, -1);
    check(lockOut, 1'b1, "R1 R9 accumulation cleared by restart");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule